// File: doc/BRIEF.md
# SPI Transfer Run/Stop Controller

This block decides when a serial-peripheral frame engine may work. It holds a two-state machine, STOPPED and RUNNING. While RUNNING, the master transmit side gets one frame-start grant per frame and the slave side may answer an incoming select. While STOPPED, neither side may begin anything, and software may rewrite the engine's configuration without risk.

Three stop sources are watched on every rising clock edge: an end-of-queue flag, a halt bit, and a freeze that applies only when a debug request and a freeze enable are both high. If any of them is active while a frame is in flight, the controller lets that frame finish and stops on the edge where the frame-done pulse arrives. A debug request with the freeze enable low has no effect. The shift register and bit clock are outside this block. The frame engine reports the end of each frame with a one-cycle `frameDone` pulse.

Top module: `spi_runstop_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the controller is in STOPPED: `running`=0, `cfgSafe`=1 and `frameGrant`=0.
- R2: From STOPPED, the controller enters RUNNING on the next rising edge at which `eoqFlag`=0, `haltBit`=0 and not (`dbgReq`=1 and `freezeEn`=1).
- R3: From RUNNING with no frame in flight, any one of `eoqFlag`=1, `haltBit`=1, or (`dbgReq`=1 and `freezeEn`=1) moves the controller to STOPPED on the next rising edge.
- R4: A stop condition raised while a frame is in flight keeps `running`=1 until the edge on which `frameDone`=1. The controller enters STOPPED on that edge.
- R5: `running` is 1 exactly in RUNNING and 0 in STOPPED.
- R6: In STOPPED, `frameGrant`=0 whatever `masterReq` is, and `slaveRespEn`=0 whatever `slaveSel` is.
- R7: With `freezeEn`=0, `dbgReq` has no effect on starting or stopping.
- R8: `cfgSafe`=1 exactly when the controller is in STOPPED.
- R9: Conditions are only sampled at rising edges. A start condition that appears and clears between two edges causes no transition.
- R10: If a stop condition is present in the cycle where `frameDone`=1, `frameGrant` is 0 in that cycle, and the controller is in STOPPED after that edge.
- R11: In RUNNING, with `masterReq` held at 1 and no stop condition, `frameGrant` is a one-cycle pulse. It is issued when no frame is in flight. The next pulse comes one cycle after the `frameDone` of the granted frame. A slave frame begins when `slaveSel` rises while RUNNING with no frame in flight and no grant issued in that cycle. While RUNNING, `slaveRespEn` follows `slaveSel`.
- R12: Reset also discards a frame in flight, so that the first cycle in RUNNING after reset may grant at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| eoqFlag | input | 1 | End-of-queue flag; stop source |
| haltBit | input | 1 | Halt control; stop source |
| freezeEn | input | 1 | Lets a debug request freeze transfers |
| dbgReq | input | 1 | Debug request from an external controller |
| frameDone | input | 1 | One-cycle pulse at the end of a frame |
| masterReq | input | 1 | Master side wants to start a frame |
| slaveSel | input | 1 | Slave select from the bus side |
| running | output | 1 | 1 in RUNNING, 0 in STOPPED |
| frameGrant | output | 1 | One-cycle permission to start a master frame |
| slaveRespEn | output | 1 | Slave side may answer the transfer |
| cfgSafe | output | 1 | Configuration writes are safe |

## Verification
On every cycle, the assertions check the following:
- `cfgSafe` is the inverse of `running`.
- No grant or slave response appears while stopped.
- A grant never appears with a frame in flight, and never in two cycles in a row.
- A start condition while stopped always leads to RUNNING.
- An in-flight frame without its done pulse always keeps the controller RUNNING.

Only the bench's scenarios can show the following:
- Each stop source acts on its own.
- A debug request without freeze is ignored.
- A condition that clears between edges causes no transition.
- Grants are paced by the frame-done pulses.
- A stop that coincides with frame completion takes effect on that very edge.

// File: rtl/spi_runstop_pkg.sv
package spi_runstop_pkg;

  typedef enum logic {
    ST_STOPPED = 1'b0,
    ST_RUNNING = 1'b1
  } runState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic runEn;    // state is RUNNING
    logic stopReq;  // some stop source is active this cycle
  } ctlStrobe_t;

endpackage

// File: rtl/spi_runstop_fsm.sv
module spi_runstop_fsm
  import spi_runstop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       eoqFlag,
  input  logic       haltBit,
  input  logic       freezeEn,
  input  logic       dbgReq,
  input  logic       frameDone,
  input  logic       inFrame,
  output ctlStrobe_t ctl
);

  runState_t state, stateNext;
  logic      stopCond;
  logic      frameBoundary;

  // freeze acts only when both debug request and enable are set
  assign stopCond      = eoqFlag | haltBit | (dbgReq & freezeEn);
  assign frameBoundary = ~inFrame | frameDone;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_STOPPED: if (!stopCond) stateNext = ST_RUNNING;
      ST_RUNNING: if (stopCond && frameBoundary) stateNext = ST_STOPPED;
      default:    stateNext = ST_STOPPED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_STOPPED;
    else       state <= stateNext;
  end

  assign ctl.runEn   = (state == ST_RUNNING);
  assign ctl.stopReq = stopCond;

endmodule

// File: rtl/spi_runstop_dp.sv
module spi_runstop_dp
  import spi_runstop_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  input  logic       frameDone,
  input  logic       masterReq,
  input  logic       slaveSel,
  output logic       inFrame,
  output logic       frameGrant,
  output logic       slaveRespEn
);

  logic slaveSelQ;
  logic slaveRise;
  logic canStart;
  logic slaveAccept;

  assign canStart    = ctl.runEn & ~ctl.stopReq & ~inFrame;
  assign frameGrant  = canStart & masterReq;
  assign slaveRise   = slaveSel & ~slaveSelQ;
  assign slaveAccept = canStart & slaveRise & ~frameGrant;
  assign slaveRespEn = ctl.runEn & slaveSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame   <= 1'b0;
      slaveSelQ <= 1'b0;
    end else begin
      slaveSelQ <= slaveSel;
      if (frameGrant || slaveAccept) inFrame <= 1'b1;
      else if (frameDone)            inFrame <= 1'b0;
    end
  end

endmodule

// File: rtl/spi_runstop_ctrl.sv
module spi_runstop_ctrl
  import spi_runstop_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic eoqFlag,
  input  logic haltBit,
  input  logic freezeEn,
  input  logic dbgReq,
  input  logic frameDone,
  input  logic masterReq,
  input  logic slaveSel,
  output logic running,
  output logic frameGrant,
  output logic slaveRespEn,
  output logic cfgSafe
);

  ctlStrobe_t ctl;
  logic       inFrame;

  spi_runstop_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .eoqFlag   (eoqFlag),
    .haltBit   (haltBit),
    .freezeEn  (freezeEn),
    .dbgReq    (dbgReq),
    .frameDone (frameDone),
    .inFrame   (inFrame),
    .ctl       (ctl)
  );

  spi_runstop_dp u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .frameDone   (frameDone),
    .masterReq   (masterReq),
    .slaveSel    (slaveSel),
    .inFrame     (inFrame),
    .frameGrant  (frameGrant),
    .slaveRespEn (slaveRespEn)
  );

  assign running = ctl.runEn;
  assign cfgSafe = ~ctl.runEn;

endmodule

// File: rtl/spi_runstop_chk.sv
module spi_runstop_chk (
  input logic clk,
  input logic rstN,
  input logic eoqFlag,
  input logic haltBit,
  input logic freezeEn,
  input logic dbgReq,
  input logic frameDone,
  input logic inFrame,
  input logic running,
  input logic frameGrant,
  input logic slaveRespEn,
  input logic cfgSafe
);

  // R8
  cfg_safe_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgSafe == !running);

  // R6
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> (!frameGrant && !slaveRespEn));

  // R11
  grant_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameGrant |-> !inFrame);

  // R11
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameGrant |=> !frameGrant);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !eoqFlag && !haltBit && !(dbgReq && freezeEn)) |=> running);

  // R4
  defer_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && inFrame && !frameDone) |=> running);

endmodule

bind spi_runstop_ctrl spi_runstop_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .eoqFlag     (eoqFlag),
  .haltBit     (haltBit),
  .freezeEn    (freezeEn),
  .dbgReq      (dbgReq),
  .frameDone   (frameDone),
  .inFrame     (inFrame),
  .running     (running),
  .frameGrant  (frameGrant),
  .slaveRespEn (slaveRespEn),
  .cfgSafe     (cfgSafe)
);

// File: tb/sim_spi_runstop_ctrl.sv
`timescale 1ns/1ps
module sim_spi_runstop_ctrl;

  logic clk = 1'b0;
  logic rstN, eoqFlag, haltBit, freezeEn, dbgReq, frameDone, masterReq, slaveSel;
  logic running, frameGrant, slaveRespEn, cfgSafe;

  int nChecks = 0;
  int nFail   = 0;

  always #5 clk = ~clk;

  spi_runstop_ctrl u0 (
    .clk(clk), .rstN(rstN), .eoqFlag(eoqFlag), .haltBit(haltBit),
    .freezeEn(freezeEn), .dbgReq(dbgReq), .frameDone(frameDone),
    .masterReq(masterReq), .slaveSel(slaveSel), .running(running),
    .frameGrant(frameGrant), .slaveRespEn(slaveRespEn), .cfgSafe(cfgSafe)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // advance one rising edge; return just after the following falling edge + 1ns
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic idleInputs();
    eoqFlag = 0; haltBit = 0; freezeEn = 0; dbgReq = 0;
    frameDone = 0; masterReq = 0; slaveSel = 0;
  endtask

  task automatic doReset();
    rstN = 0; haltBit = 1;
    step(); step();
    rstN = 1;
    #1;
  endtask

  task automatic testReset();
    doReset();
    check("R1", "running after reset", running, 1'b0);
    check("R1", "cfgSafe after reset", cfgSafe, 1'b1);
    check("R1", "grant after reset", frameGrant, 1'b0);
  endtask

  task automatic testStartBlocked();
    masterReq = 1; slaveSel = 1;
    haltBit = 1; step();
    check("R2", "halt blocks start", running, 1'b0);
    check("R6", "no grant while stopped", frameGrant, 1'b0);
    check("R6", "no slave response while stopped", slaveRespEn, 1'b0);
    haltBit = 0; eoqFlag = 1; step();
    check("R2", "eoq blocks start", running, 1'b0);
    eoqFlag = 0; dbgReq = 1; freezeEn = 1; step();
    check("R2", "freeze blocks start", running, 1'b0);
    check("R8", "cfgSafe while stopped", cfgSafe, 1'b1);
    masterReq = 0; slaveSel = 0;
    freezeEn = 0; step();
    check("R7", "debug without freeze starts", running, 1'b1);
    check("R5", "cfgSafe low when running", cfgSafe, 1'b0);
    dbgReq = 0;
  endtask

  task automatic testGlitch();
    haltBit = 1; step();
    check("R3", "halt stops idle controller", running, 1'b0);
    // clear halt between edges only
    #1 haltBit = 0;
    #2 haltBit = 1;
    step();
    check("R9", "glitch between edges ignored", running, 1'b0);
  endtask

  task automatic testGrants();
    int grants = 0;
    haltBit = 0; step();
    check("R2", "start after halt cleared", running, 1'b1);
    masterReq = 1; #1;
    check("R11", "grant when idle", frameGrant, 1'b1);
    for (int f = 0; f < 3; f++) begin
      for (int c = 0; c < 4; c++) begin
        if (frameGrant) grants++;
        step();
      end
      frameDone = 1; #1;
      if (frameGrant) grants++;
      step();
      frameDone = 0; #1;
    end
    // one grant at start plus one after each of the 3 frame-done pulses,
    // but the last pulse's grant is counted below
    if (frameGrant) grants++;
    check("R11", "one grant per completed frame", grants == 4, 1'b1);
    dbgReq = 1; #1;
    check("R7", "debug without freeze keeps grant", frameGrant, 1'b1);
    dbgReq = 0;
  endtask

  task automatic testDeferredStop();
    // frame granted in previous cycle is now in flight
    step();
    masterReq = 1; haltBit = 1; step();
    check("R4", "running held during frame", running, 1'b1);
    step();
    check("R4", "still running before frame done", running, 1'b1);
    frameDone = 1; #1;
    check("R10", "no grant on stopping edge", frameGrant, 1'b0);
    step();
    frameDone = 0; #1;
    check("R10", "stopped after frame done edge", running, 1'b0);
    check("R6", "no grant after stop", frameGrant, 1'b0);
  endtask

  task automatic testFreezeStop();
    haltBit = 0; masterReq = 0; step();
    check("R2", "restart", running, 1'b1);
    dbgReq = 1; freezeEn = 1; step();
    check("R3", "freeze stops", running, 1'b0);
    dbgReq = 0; freezeEn = 0; step();
    eoqFlag = 1; step();
    check("R3", "eoq stops", running, 1'b0);
    eoqFlag = 0;
  endtask

  task automatic testSlave();
    step();
    check("R2", "restart for slave", running, 1'b1);
    slaveSel = 1; #1;
    check("R11", "slave response enabled", slaveRespEn, 1'b1);
    step();
    // slave frame in flight: stop must wait
    haltBit = 1; step();
    check("R4", "slave frame defers stop", running, 1'b1);
    frameDone = 1; step();
    frameDone = 0; slaveSel = 0; #1;
    check("R4", "stop after slave frame", running, 1'b0);
    haltBit = 0;
  endtask

  task automatic testResetMidFrame();
    masterReq = 1; step();
    check("R2", "running before mid-frame reset", running, 1'b1);
    step();
    check("R11", "no grant while in flight", frameGrant, 1'b0);
    rstN = 0; step();
    rstN = 1; #1;
    check("R12", "stopped after reset", running, 1'b0);
    step();
    check("R12", "grant at once after reset", frameGrant, 1'b1);
    masterReq = 0;
  endtask

  initial begin
    idleInputs();
    rstN = 0;
    fork
      begin
        testReset();
        testStartBlocked();
        testGlitch();
        testGrants();
        testDeferredStop();
        testFreezeStop();
        testSlave();
        testResetMidFrame();
      end
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFail++;
        $display("FAIL watchdog: actual=expired expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule